// File: doc/BRIEF.md
# Engine Operating-State Controller

This block holds the operating state of a serial controller engine. A host register interface writes a requested state (RESET, RUN or PAUSE), pulses a software reset, and enables the tagged I2C master mode through a separate configuration write. The block reports the current state, a valid flag, a sticky error flag and a master-ready flag in one readback byte. From the settled state it decodes three gate signals for the downstream engines: run, hold and clear.

A state change does not take effect at once. A change must cross a few bus-clock cycles and then a few serial-clock cycles. Both are modelled as fixed counters: `BUS_CYC` bus cycles, then `SER_CYC` serial ticks of `SER_DIV` bus cycles each. While the change is pending, the valid flag reads 0 and the old state is still reported. A write that arrives while valid is 0 is dropped and is flagged as an error. Host software is expected to poll the valid flag before each new state write. At the end of every transfer sequence, whether it passed or failed, host software returns the engine to RESET.

Top module: `eng_state_ctrl`

## Requirements
- R1: After `rst_n` is released, `state_rd` reads 0x04 and `eng_clr` is 1. The readback layout is: bits [1:0] state (RESET=0, RUN=1, PAUSE=3), bit 2 valid, bit 3 sticky error, bit 4 master ready, bits [7:5] zero.
- R2: A write of code 0, 1 or 3 is accepted when it arrives while valid is 1 and `sw_rst` is low. Valid then reads 0 from the next cycle for exactly SETTLE = BUS_CYC + SER_CYC*SER_DIV cycles (9 with the defaults). After that, valid reads 1 together with the new state.
- R3: While valid is 0, the state field and the gate outputs keep showing the previous state.
- R4: A state write that arrives while valid is 0 changes neither the pending state nor the length of the window. The error bit reads 1 from the next cycle.
- R5: A write of the unused code 2 while valid is 1 leaves the state unchanged and keeps valid at 1. The error bit reads 1 from the next cycle.
- R6: `run_en` is 1 only in RUN, `pause_hold` only in PAUSE and `eng_clr` only in RESET. Exactly one of the three is 1 at any time.
- R7: A master-config write (`mgen_wr`) copies `mgen_data` into bit 4 of the readback on the next cycle.
- R8: A `sw_rst` pulse has priority over any write in the same cycle. On the next cycle the state is RESET, with valid, error and master ready all at 0. Valid returns to 1 after SETTLE cycles.
- R9: The error bit stays at 1 until a `sw_rst` pulse clears it.
- R10: Host software returns the engine to RESET by writing code 0. This takes the same settling window as any other change, after which `eng_clr` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus-interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_wr | input | 1 | State write strobe |
| st_wdata | input | 2 | Requested state code |
| sw_rst | input | 1 | Software reset pulse |
| mgen_wr | input | 1 | Master-config write strobe |
| mgen_data | input | 1 | Tagged master-mode enable value |
| state_rd | output | 8 | Readback: state, valid, error, master ready |
| run_en | output | 1 | Downstream transfers may run |
| pause_hold | output | 1 | Downstream transfers hold |
| eng_clr | output | 1 | Downstream engines cleared |

## Verification
A settling counter that ends one cycle early or late shows up directly at the ports. The valid bit rises in the wrong cycle, and the new state appears with it. The bench checks every cycle of each window, so such an error is caught within SETTLE+1 cycles of the write. A wrongly accepted write during a window changes the state or restarts the window. Either shows at the ports when the window ends, in the state field and the gate outputs. A lost error or master flag shows in the readback byte on the cycle after the stimulus.

// File: rtl/eng_state_pkg.sv
package eng_state_pkg;

    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_RUN   = 2'd1,
        ST_PAUSE = 2'd3
    } eng_st_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_BUS  = 2'd1,
        PH_SER  = 2'd2
    } settle_ph_e;

    localparam int RD_VALID_BIT = 2;
    localparam int RD_ERR_BIT   = 3;
    localparam int RD_MGEN_BIT  = 4;

    function automatic logic code_legal(input logic [1:0] code);
        return code != 2'd2;
    endfunction

endpackage

// File: rtl/settle_timer.sv
module settle_timer
    import eng_state_pkg::*;
#(
    parameter int BUS_CYC = 3,
    parameter int SER_CYC = 3,
    parameter int SER_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int BW = $clog2(BUS_CYC + 1);
    localparam int SW = $clog2(SER_CYC + 1);
    localparam int DW = $clog2(SER_DIV + 1);

    typedef struct packed {
        settle_ph_e    ph;
        logic [BW-1:0] bcnt;
        logic [SW-1:0] scnt;
        logic [DW-1:0] dcnt;
    } tmr_t;

    tmr_t tmr_q, tmr_d;
    logic done_c;

    always_comb begin
        tmr_d  = tmr_q;
        done_c = 1'b0;
        case (tmr_q.ph)
            PH_BUS: begin
                if (tmr_q.bcnt == '0) begin
                    tmr_d.ph   = PH_SER;
                    tmr_d.scnt = SW'(SER_CYC - 1);
                    tmr_d.dcnt = DW'(SER_DIV - 1);
                end else begin
                    tmr_d.bcnt = tmr_q.bcnt - 1'b1;
                end
            end
            PH_SER: begin
                if (tmr_q.dcnt == '0) begin
                    if (tmr_q.scnt == '0) begin
                        done_c   = 1'b1;
                        tmr_d.ph = PH_IDLE;
                    end else begin
                        tmr_d.scnt = tmr_q.scnt - 1'b1;
                        tmr_d.dcnt = DW'(SER_DIV - 1);
                    end
                end else begin
                    tmr_d.dcnt = tmr_q.dcnt - 1'b1;
                end
            end
            default: ;
        endcase
        if (start) begin
            tmr_d.ph   = PH_BUS;
            tmr_d.bcnt = BW'(BUS_CYC - 1);
            tmr_d.scnt = SW'(SER_CYC - 1);
            tmr_d.dcnt = DW'(SER_DIV - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '{ph: PH_IDLE, bcnt: '0, scnt: '0, dcnt: '0};
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign done = done_c;

    // R2
    bus_to_ser_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.ph == PH_BUS && !start) |=> (tmr_q.ph != PH_IDLE));

endmodule

// File: rtl/eng_state_decode.sv
module eng_state_decode
    import eng_state_pkg::*;
(
    input  eng_st_e cur,
    output logic    run_en,
    output logic    pause_hold,
    output logic    eng_clr
);
    always_comb begin
        run_en     = 1'b0;
        pause_hold = 1'b0;
        eng_clr    = 1'b0;
        case (cur)
            ST_RUN:   run_en     = 1'b1;
            ST_PAUSE: pause_hold = 1'b1;
            default:  eng_clr    = 1'b1;
        endcase
    end
endmodule

// File: rtl/eng_state_ctrl.sv
module eng_state_ctrl
    import eng_state_pkg::*;
#(
    parameter int BUS_CYC = 3,
    parameter int SER_CYC = 3,
    parameter int SER_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       st_wr,
    input  logic [1:0] st_wdata,
    input  logic       sw_rst,
    input  logic       mgen_wr,
    input  logic       mgen_data,
    output logic [7:0] state_rd,
    output logic       run_en,
    output logic       pause_hold,
    output logic       eng_clr
);
    typedef struct packed {
        eng_st_e cur;
        eng_st_e pend;
        logic    valid;
        logic    err;
        logic    mgen;
    } ctl_t;

    ctl_t ctl_q, ctl_d;
    logic accept, tmr_start, tmr_done;

    settle_timer #(
        .BUS_CYC(BUS_CYC),
        .SER_CYC(SER_CYC),
        .SER_DIV(SER_DIV)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .done  (tmr_done)
    );

    always_comb begin
        ctl_d     = ctl_q;
        accept    = st_wr && ctl_q.valid && code_legal(st_wdata) && !sw_rst;
        tmr_start = accept || sw_rst;
        if (sw_rst) begin
            ctl_d.cur   = ST_RESET;
            ctl_d.pend  = ST_RESET;
            ctl_d.valid = 1'b0;
            ctl_d.err   = 1'b0;
            ctl_d.mgen  = 1'b0;
        end else begin
            if (accept) begin
                ctl_d.pend  = eng_st_e'(st_wdata);
                ctl_d.valid = 1'b0;
            end else if (st_wr) begin
                ctl_d.err = 1'b1;
            end
            if (tmr_done && !ctl_q.valid) begin
                ctl_d.cur   = ctl_q.pend;
                ctl_d.valid = 1'b1;
            end
            if (mgen_wr) begin
                ctl_d.mgen = mgen_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{cur: ST_RESET, pend: ST_RESET, valid: 1'b1,
                       err: 1'b0, mgen: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    eng_state_decode u_dec (
        .cur        (ctl_q.cur),
        .run_en     (run_en),
        .pause_hold (pause_hold),
        .eng_clr    (eng_clr)
    );

    always_comb begin
        state_rd               = '0;
        state_rd[1:0]          = ctl_q.cur;
        state_rd[RD_VALID_BIT] = ctl_q.valid;
        state_rd[RD_ERR_BIT]   = ctl_q.err;
        state_rd[RD_MGEN_BIT]  = ctl_q.mgen;
    end

    // R2
    drop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && state_rd[RD_VALID_BIT] && st_wdata != 2'd2 && !sw_rst)
        |=> !state_rd[RD_VALID_BIT]);

    // R2
    done_when_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_done |-> !ctl_q.valid);

    // R3
    hold_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q.valid && !tmr_done && !sw_rst) |=> $stable(ctl_q.cur));

    // R4
    late_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && !state_rd[RD_VALID_BIT] && !sw_rst) |=> state_rd[RD_ERR_BIT]);

    // R6
    onehot_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({run_en, pause_hold, eng_clr}));

    // R8
    swrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (state_rd[4:0] == 5'b00000));

    // R9
    sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_rd[RD_ERR_BIT] && !sw_rst) |=> state_rd[RD_ERR_BIT]);

endmodule

// File: tb/sim_eng_state_ctrl.sv
`timescale 1ns/1ps
module sim_eng_state_ctrl;
    localparam int BUS_CYC = 3;
    localparam int SER_CYC = 3;
    localparam int SER_DIV = 2;
    localparam int SETTLE  = BUS_CYC + SER_CYC * SER_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       st_wr = 1'b0;
    logic [1:0] st_wdata = 2'd0;
    logic       sw_rst = 1'b0;
    logic       mgen_wr = 1'b0;
    logic       mgen_data = 1'b0;
    logic [7:0] state_rd;
    logic       run_en, pause_hold, eng_clr;

    always #2.5 clk = ~clk;

    eng_state_ctrl #(
        .BUS_CYC(BUS_CYC), .SER_CYC(SER_CYC), .SER_DIV(SER_DIV)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .st_wr(st_wr), .st_wdata(st_wdata),
        .sw_rst(sw_rst), .mgen_wr(mgen_wr), .mgen_data(mgen_data),
        .state_rd(state_rd), .run_en(run_en), .pause_hold(pause_hold),
        .eng_clr(eng_clr)
    );

    typedef struct {
        logic [7:0] word;
        logic [2:0] gates;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   drv_done = 1'b0;

    // model state tracked by the driver from the requirements
    logic [1:0] m_cur = 2'd0;
    logic       m_err = 1'b0;
    logic       m_mg  = 1'b0;

    function automatic logic [2:0] gates_of(input logic [1:0] c);
        case (c)
            2'd1:    return 3'b100;
            2'd3:    return 3'b010;
            default: return 3'b001;
        endcase
    endfunction

    task automatic step(input logic wr, input logic [1:0] wd, input logic rs,
                        input logic mw, input logic md,
                        input logic [1:0] e_cur, input logic e_v,
                        input logic e_err, input logic e_mg, input string tag);
        exp_t e;
        @(negedge clk);
        st_wr = wr; st_wdata = wd; sw_rst = rs; mgen_wr = mw; mgen_data = md;
        e.word  = {3'b000, e_mg, e_err, e_v, e_cur};
        e.gates = gates_of(e_cur);
        e.tag   = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(0, 2'd0, 0, 0, 0, m_cur, 1'b1, m_err, m_mg, tag);
    endtask

    // accepted write, optional second write poked inside the window
    task automatic change(input logic [1:0] code, input int poke_at,
                          input logic [1:0] poke_code, input string tag);
        for (int i = 0; i <= SETTLE; i++) begin
            logic wr;
            logic [1:0] wd;
            wr = (i == 0) || (i == poke_at);
            wd = (i == 0) ? code : poke_code;
            if (i == poke_at && poke_at > 0) m_err = 1'b1;
            step(wr, wd, 0, 0, 0, (i == SETTLE) ? code : m_cur,
                 (i == SETTLE), m_err, m_mg, tag);
        end
        m_cur = code;
    endtask

    task automatic soft_reset(input logic with_wr, input string tag);
        m_cur = 2'd0; m_err = 1'b0; m_mg = 1'b0;
        for (int i = 0; i <= SETTLE; i++) begin
            step((i == 0) && with_wr, 2'd1, (i == 0), (i == 0) && with_wr, 1'b1,
                 2'd0, (i == SETTLE), 1'b0, 1'b0, tag);
        end
    endtask

    // monitor: compares one expected item per cycle, after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_chk++;
                if (state_rd !== e.word || {run_en, pause_hold, eng_clr} !== e.gates) begin
                    n_bad++;
                    $display("FAIL %s: state_rd=%02h gates=%03b expected state_rd=%02h gates=%03b",
                             e.tag, state_rd, {run_en, pause_hold, eng_clr}, e.word, e.gates);
                end
            end
        end
    end

    initial begin
        int wd_cnt;
        wd_cnt = 0;
        while (!drv_done && wd_cnt < 5000) begin
            @(posedge clk);
            wd_cnt++;
        end
        if (!drv_done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 5000", wd_cnt);
        end else begin
            repeat (3) @(posedge clk);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset readback and clear gate
        idle("R1 reset state");
        idle("R1 reset state hold");
        // R7 master enable
        m_mg = 1'b1;
        step(0, 2'd0, 0, 1, 1, m_cur, 1'b1, m_err, m_mg, "R7 master ready set");
        // R2 R3 R6 change to RUN, window checked cycle by cycle
        change(2'd1, 0, 2'd0, "R2 R3 R6 reset to run");
        idle("R6 run gate");
        // R4 write during window ignored, window length unchanged
        change(2'd3, 4, 2'd0, "R4 late write to reset ignored");
        idle("R6 pause gate");
        // R9 error stays across another change
        change(2'd1, 0, 2'd0, "R9 sticky error across change");
        // R7 master disable
        m_mg = 1'b0;
        step(0, 2'd0, 0, 1, 0, m_cur, 1'b1, m_err, m_mg, "R7 master ready clear");
        // R8 soft reset in mid-window, overriding a simultaneous write
        step(1, 2'd3, 0, 0, 0, m_cur, 1'b0, m_err, m_mg, "R3 pending pause");
        step(0, 2'd0, 0, 0, 0, m_cur, 1'b0, m_err, m_mg, "R3 pending pause");
        soft_reset(1'b1, "R8 soft reset mid window");
        idle("R8 reset settled");
        // R5 unused code rejected
        m_err = 1'b1;
        step(1, 2'd2, 0, 0, 0, m_cur, 1'b1, m_err, m_mg, "R5 code 2 rejected");
        idle("R5 state unchanged");
        soft_reset(1'b0, "R9 error cleared by soft reset");
        // R10 end-of-sequence return to RESET from RUN
        change(2'd1, 0, 2'd0, "R2 run again");
        change(2'd0, 0, 2'd0, "R10 return to reset");
        idle("R10 clear gate");
        @(negedge clk);
        st_wr = 0; sw_rst = 0; mgen_wr = 0;
        repeat (2) @(negedge clk);
        drv_done = 1'b1;
    end

endmodule